// File: doc/BRIEF.md
# Multichannel Grayscale PWM Generator

This block turns sixteen twelve-bit brightness codes into sixteen on/off channel enables. One shared counter, clocked by a dedicated grayscale clock, measures out each PWM cycle. Each channel compares its own code against that counter. A channel is lit for as many clocks as its code. The counter stops at full scale and does not wrap, so every cycle is a single shot. A new cycle starts when the blanking input is released. Raising blank again turns every channel off and returns the counter to zero.

To limit the current step when many channels switch together, channel n follows channel 0 by n steps of a configurable number of grayscale clocks, both when it turns on and when it turns off. The grayscale codes come from an external register bank as one packed word. They are compared live, so a code changed mid-cycle acts at once. The register bank is expected to update only between cycles. The blank input is asynchronous and passes through a two-flop synchronizer. All other logic runs on the grayscale clock.

Top module: `pwm_gray_top`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every channel enable and the cycle-complete output are low.
- R2: A channel whose code is zero stays off for the whole cycle.
- R3: After blank falls, two grayscale-clock edges pass through the synchronizer. The third edge is the first counting edge, and channel 0 turns on there if its code is nonzero.
- R4: A channel with code v in 1..4094 stays on for exactly v grayscale clocks. It turns off at the edge where the counter passes v.
- R5: The counter saturates at 4095 and stays there while blank is low. Reaching 4095 forces every channel off. A code of 4095 therefore gives 4094 lit clocks. The cycle-complete output pulses high for exactly one clock, in the cycle the counter first holds 4095.
- R6: Once the synchronized blank is high, every channel enable is low and the counter returns to zero. A blank raised mid-cycle therefore cuts the cycle short, and the next release restarts at full length.
- R7: Channel n turns on and turns off exactly n × STEP_CYCLES grayscale clocks after channel 0 would for the same code (STEP_CYCLES defaults to 1).
- R8: A change to a channel's code during a cycle takes effect from the next counting edge. Raising the code extends the on time. Lowering it below the current count turns the channel off at that edge.
- R9: The code for channel n is taken from bits [12n+11:12n] of the grayscale word, so channel 0 sits in the lowest twelve bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Grayscale clock; all state advances on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| blankIn | input | 1 | Asynchronous blanking request; high forces all channels off and clears the counter |
| gsWord | input | 192 | Packed twelve-bit codes, channel n at bits [12n+11:12n] |
| chanOn | output | 16 | Channel enables, bit n for channel n |
| cycleDone | output | 1 | One-clock pulse when the counter saturates at full scale |

## Verification
The bench first drives a ramp of distinct small codes with zero, one and two among them. The zero code shows a channel that never lights, and the one and two codes expose off-by-one errors in the on window. The distinct lengths also separate the per-channel stagger from the compare itself. A second pattern runs near-full-scale codes to saturation, which checks where the forced turn-off falls and the single completion pulse. A third pattern uses equal codes that are blanked partway through, then run again in full, to show that blank clears the counter rather than pausing it. Finally, one code is raised and another lowered mid-cycle, which shows that comparison uses the live code and not a copy taken at cycle start.

// File: rtl/pwm_gray_pkg.sv
package pwm_gray_pkg;
  localparam int GS_W   = 12;
  localparam int CHAN_N = 16;

  // strobes handed from control to datapath each grayscale clock
  typedef struct packed {
    logic            blank;    // synchronized blank level
    logic [GS_W-1:0] cntNext;  // value the shared counter takes at this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_gray_ctrl.sv
module pwm_gray_ctrl
  import pwm_gray_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        blankIn,
  output ctrlStrobe_t strobe,
  output logic        cycleDone
);
  localparam logic [GS_W-1:0] FULL     = '1;
  localparam logic [GS_W-1:0] NEAR_END = FULL - 1'b1;

  logic [1:0]      syncQ;
  logic            blankSync;
  logic [GS_W-1:0] cnt;
  logic [GS_W-1:0] cntNext;

  // two-flop synchronizer; comes out of reset in the blanked state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], blankIn};
  end
  assign blankSync = syncQ[1];

  always_comb begin
    if (blankSync)        cntNext = '0;
    else if (cnt == FULL) cntNext = FULL;
    else                  cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      cycleDone <= 1'b0;
    end else begin
      cnt       <= cntNext;
      cycleDone <= !blankSync && (cnt == NEAR_END);
    end
  end

  assign strobe.blank   = blankSync;
  assign strobe.cntNext = cntNext;
endmodule

// File: rtl/pwm_gray_dp.sv
module pwm_gray_dp
  import pwm_gray_pkg::*;
#(
  parameter int CHANNELS    = CHAN_N,
  parameter int STEP_CYCLES = 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [CHANNELS*GS_W-1:0] gsWord,
  output logic [CHANNELS-1:0]      baseOn,
  output logic [CHANNELS-1:0]      chanOn
);
  localparam logic [GS_W-1:0] FULL = '1;

  // count window shared by all channels: counting and not yet saturated
  logic inWindow;
  assign inWindow = !strobe.blank && (strobe.cntNext != '0) && (strobe.cntNext != FULL);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    localparam int DEPTH = ch * STEP_CYCLES;
    logic [GS_W-1:0] code;
    logic            hit;
    logic            lagged;

    assign code = gsWord[ch*GS_W +: GS_W];
    assign hit  = inWindow && (strobe.cntNext <= code);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) baseOn[ch] <= 1'b0;
      else       baseOn[ch] <= hit;
    end

    if (DEPTH == 0) begin : g_direct
      assign lagged = baseOn[ch];
    end else if (DEPTH == 1) begin : g_one
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             stage <= 1'b0;
        else if (strobe.blank) stage <= 1'b0;
        else                   stage <= baseOn[ch];
      end
      assign lagged = stage;
    end else begin : g_chain
      logic [DEPTH-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             pipe <= '0;
        else if (strobe.blank) pipe <= '0;
        else                   pipe <= {pipe[DEPTH-2:0], baseOn[ch]};
      end
      assign lagged = pipe[DEPTH-1];
    end

    assign chanOn[ch] = lagged && !strobe.blank;
  end
endmodule

// File: rtl/pwm_gray_top.sv
module pwm_gray_top
  import pwm_gray_pkg::*;
#(
  parameter int CHANNELS    = CHAN_N,
  parameter int STEP_CYCLES = 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     blankIn,
  input  logic [CHANNELS*GS_W-1:0] gsWord,
  output logic [CHANNELS-1:0]      chanOn,
  output logic                     cycleDone
);
  ctrlStrobe_t         strobe;
  logic [CHANNELS-1:0] baseOn;

  pwm_gray_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .blankIn   (blankIn),
    .strobe    (strobe),
    .cycleDone (cycleDone)
  );

  pwm_gray_dp #(
    .CHANNELS    (CHANNELS),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .gsWord (gsWord),
    .baseOn (baseOn),
    .chanOn (chanOn)
  );
endmodule

// File: rtl/pwm_gray_chk.sv
module pwm_gray_chk
  import pwm_gray_pkg::*;
#(
  parameter int CHANNELS = CHAN_N
)(
  input logic                clk,
  input logic                rstN,
  input logic                blankSync,
  input logic [GS_W-1:0]     cntNext,
  input logic                cycleDone,
  input logic [CHANNELS-1:0] baseOn,
  input logic [GS_W-1:0]     gsLow
);
  localparam logic [GS_W-1:0] FULL = '1;

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntNext) == FULL && !blankSync) |-> cntNext == FULL);

  // R5
  done_at_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> $past(cntNext) == FULL);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R6
  blank_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    blankSync |=> baseOn == '0);

  // R2
  zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseOn[0] |-> $past(gsLow) != '0);
endmodule

bind pwm_gray_top pwm_gray_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .blankSync (strobe.blank),
  .cntNext   (strobe.cntNext),
  .cycleDone (cycleDone),
  .baseOn    (baseOn),
  .gsLow     (gsWord[11:0])
);

// File: tb/pwm_gray_top_bench.sv
module pwm_gray_top_bench;
  localparam int NCH  = 16;
  localparam int STEP = 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              blankIn = 1'b1;
  logic [NCH*12-1:0] gsWord = '0;
  logic [NCH-1:0]    chanOn;
  logic              cycleDone;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [NCH-1:0] on;
    logic           done;
    string          tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  pwm_gray_top #(.CHANNELS(NCH), .STEP_CYCLES(STEP)) u_pwm_gray_top (
    .clk(clk), .rstN(rstN), .blankIn(blankIn), .gsWord(gsWord),
    .chanOn(chanOn), .cycleDone(cycleDone)
  );

  // monitor: pops one expected item per clock and compares away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      compared++;
      if (chanOn !== e.on || cycleDone !== e.done) begin
        mismatched++;
        $display("FAIL %s: chanOn=%h done=%b expected chanOn=%h done=%b",
                 e.tag, chanOn, cycleDone, e.on, e.done);
      end
    end
  end

  // driver: runs one PWM cycle and pushes the expected outputs per edge
  // (R3: first counting edge is edge 3; R9: channel n at bits 12n+11:12n)
  task automatic runPhase(input logic [11:0] vals [NCH], input int nEdges,
                          input int blankAt, input int changeAt,
                          input logic [11:0] newVal0, input string tag);
    @(negedge clk);
    for (int n = 0; n < NCH; n++) gsWord[n*12 +: 12] = vals[n];
    blankIn = 1'b0;
    for (int j = 1; j <= nEdges; j++) begin
      exp_t e;
      bit blk;
      @(posedge clk);
      #1;
      if (changeAt != 0 && j == changeAt) gsWord[11:0] = newVal0;
      if (blankAt != 0 && j == blankAt - 1) blankIn = 1'b1;
      blk = (blankAt != 0) && (j >= blankAt + 1);
      for (int n = 0; n < NCH; n++) begin
        int k;
        int v;
        k = j - n * STEP;
        v = (n == 0 && changeAt != 0 && k > changeAt) ? int'(newVal0) : int'(vals[n]);
        if (v > 4094) v = 4094;
        e.on[n] = !blk && (k >= 3) && (k <= 2 + v);
      end
      e.done = (j == 4097) && !(blankAt != 0 && blankAt + 1 <= 4096);
      e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    blankIn = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      exp_t z;
      @(posedge clk);
      #1;
      if (i >= 2) begin
        z.on = '0;
        z.done = 1'b0;
        z.tag = "R6 idle after blank";
        expQ.push_back(z);
      end
    end
  endtask

  initial begin
    logic [11:0] v [NCH];
    // R1: reset state
    repeat (3) @(negedge clk);
    compared++;
    if (chanOn !== '0 || cycleDone !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: chanOn=%h done=%b expected chanOn=0 done=0", chanOn, cycleDone);
    end
    gsWord = '1;
    @(negedge clk);
    compared++;
    if (chanOn !== '0 || cycleDone !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: chanOn=%h done=%b expected chanOn=0 done=0", chanOn, cycleDone);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R7 R9: ramp of distinct small codes, zero among them
    v[0] = 12'd7; v[1] = 12'd0; v[2] = 12'd1; v[3] = 12'd2;
    for (int n = 4; n < NCH; n++) v[n] = 12'(n * 9);
    runPhase(v, 170, 0, 0, 12'd0, "R2/R3/R4/R7/R9 ramp");

    // R5: saturation, forced off, single completion pulse
    v[0] = 12'd4095; v[1] = 12'd4094; v[2] = 12'd4093; v[3] = 12'd0;
    for (int n = 4; n < NCH; n++) v[n] = 12'(4000 + n);
    runPhase(v, 4130, 0, 0, 12'd0, "R5 saturation");

    // R6: blank mid-cycle, then a full rerun from zero (R7 equal codes)
    for (int n = 0; n < NCH; n++) v[n] = 12'd100;
    runPhase(v, 40, 30, 0, 12'd0, "R6 early blank");
    runPhase(v, 130, 0, 0, 12'd0, "R6/R7 restart");

    // R8: live code changes, up and down
    v[0] = 12'd10;
    for (int n = 1; n < NCH; n++) v[n] = 12'd3;
    runPhase(v, 40, 0, 5, 12'd20, "R8 raise");
    runPhase(v, 40, 0, 8, 12'd4, "R8 lower");

    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run not finished, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule